// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Unit

This block executes a stream of operand-free stack instructions against a small hardware stack of words. A load instruction fetches a word from an external synchronous operand RAM and places it on the stack. A store instruction removes the top word and writes it back to the RAM. Four arithmetic instructions (add, subtract, multiply, divide) consume the two uppermost words and leave one result in their place. Arithmetic instructions carry no address; their operands are always implicit.

Instructions arrive on a valid/ready handshake. The unit drops ready while a load waits for its RAM data and while the serial signed divider runs. Three sticky flags report stack overflow, stack underflow and division by zero. The current stack depth is also visible. An expression such as (A-B)/(C+D*E) is evaluated by loading operands and applying operators in postfix order, then storing the result.

Top module: `stack_alu`

## Requirements
- R1: After reset, depth is 0, all three flags are 0 and ins_ready is 1.
- R2: The 3-bit ins_op field encodes 0 = load (push from RAM), 1 = store (pop to RAM), 2 = add, 3 = subtract, 4 = multiply, 5 = divide; codes 6 and 7 are accepted and change nothing.
- R3: An accepted load with the stack not full drives mem_rd_en with mem_addr = ins_addr in the accept cycle; the word returned on mem_rdata in the next cycle becomes the new top, and ins_ready is low for exactly that one cycle.
- R4: An accepted store with a non-empty stack drives mem_wr_en with mem_addr = ins_addr and mem_wdata = top in the accept cycle, and depth falls by one.
- R5: Add, subtract and multiply compute (second-from-top) op (top), keep the low word of the result, replace both entries by it (depth falls by one) and leave ins_ready high.
- R6: Divide with a non-zero top computes the signed quotient of second-from-top by top, truncated toward zero; ins_ready is low for WIDTH+1 cycles after acceptance.
- R7: Divide with a zero top replaces both entries by 0 without stalling and sets the divide-by-zero flag, which then stays set until reset.
- R8: A load with depth equal to DEPTH issues no RAM read, leaves the stack unchanged and sets the overflow flag, which stays set until reset; depth never exceeds DEPTH.
- R9: An arithmetic instruction with fewer than two entries, or a store with an empty stack, leaves the stack and RAM unchanged and sets the sticky underflow flag; underflow takes precedence over divide-by-zero detection.
- R10: The sequence load A, load B, sub, load C, load D, load E, mul, add, div, store Y writes (A-B)/(C+D*E) to Y.
- R11: While ins_ready is low, an asserted ins_valid is not accepted and causes no RAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction present |
| ins_ready | output | 1 | Unit can accept an instruction |
| ins_op | input | 3 | Operation code |
| ins_addr | input | AW | RAM address for load and store |
| mem_addr | output | AW | Operand RAM address |
| mem_rd_en | output | 1 | Operand RAM read strobe (data one cycle later) |
| mem_wr_en | output | 1 | Operand RAM write strobe |
| mem_wdata | output | WIDTH | Operand RAM write data |
| mem_rdata | input | WIDTH | Operand RAM read data |
| depth | output | CW | Number of stack entries |
| ovf_flag | output | 1 | Sticky stack overflow |
| udf_flag | output | 1 | Sticky stack underflow |
| dz_flag | output | 1 | Sticky divide by zero |

## Verification
Two conditions can meet in one accepted instruction: a divide whose top word is zero while fewer than two entries are present, and a load arriving at a full stack in the same cycle that would otherwise start a RAM read. The bench provokes the first by dividing a single zero entry and judges that only the underflow flag rises while the divide-by-zero flag stays clear and depth is untouched. It provokes the second with a ninth load and judges that no read strobe appears in the accept cycle and that the eight earlier words come back in reverse order. Stray instructions held valid during divider and load stalls check that nothing is taken while the unit is busy.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_MUL   = 3'd4,
        OP_DIV   = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DIVIDE
    } stk_state_e;

    typedef enum logic [1:0] {
        SA_NONE,
        SA_PUSH,
        SA_POP,
        SA_MERGE
    } stk_act_e;

    function automatic logic is_binary(stk_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);
    endfunction

endpackage

// File: rtl/stk_store.sv
module stk_store
    import stk_pkg::*;
#(
    parameter  int W     = 16,
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_act_e      act,
    input  logic [W-1:0]  wval,
    output logic [W-1:0]  top,
    output logic [W-1:0]  second,
    output logic [CW-1:0] count
);

    logic [W-1:0] ent [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent[g] <= '0;
                end else if (act == SA_PUSH && 32'(count) == g) begin
                    ent[g] <= wval;
                end else if (act == SA_MERGE && 32'(count) == g + 2) begin
                    ent[g] <= wval;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case (act)
                SA_PUSH:  count <= count + CW'(1);
                SA_POP:   count <= count - CW'(1);
                SA_MERGE: count <= count - CW'(1);
                default:  count <= count;
            endcase
        end
    end

    always_comb begin
        top    = '0;
        second = '0;
        if (count >= CW'(1)) top    = ent[IW'(count - CW'(1))];
        if (count >= CW'(2)) second = ent[IW'(count - CW'(2))];
    end

endmodule

// File: rtl/stk_arith.sv
module stk_arith
    import stk_pkg::*;
#(
    parameter int W = 16
) (
    input  stk_op_e      op,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res
);

    always_comb begin
        case (op)
            OP_ADD:  res = lhs + rhs;
            OP_SUB:  res = lhs - rhs;
            OP_MUL:  res = lhs * rhs;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/stk_divider.sv
module stk_divider #(
    parameter  int W  = 16,
    localparam int KW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);

    logic          running;
    logic [KW-1:0] cnt;
    logic [W-1:0]  quo;
    logic [W-1:0]  rem;
    logic [W-1:0]  dvs;
    logic          neg;
    logic [W-1:0]  mag_a;
    logic [W-1:0]  mag_b;
    logic [W:0]    trial;

    assign mag_a = dividend[W-1] ? (~dividend + 1'b1) : dividend;
    assign mag_b = divisor[W-1]  ? (~divisor + 1'b1)  : divisor;
    assign trial = {rem, quo[W-1]} - {1'b0, dvs};

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
            quo     <= '0;
            rem     <= '0;
            dvs     <= '0;
            neg     <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= KW'(W);
            quo     <= mag_a;
            rem     <= '0;
            dvs     <= mag_b;
            neg     <= dividend[W-1] ^ divisor[W-1];
        end else if (running) begin
            if (cnt != '0) begin
                if (!trial[W]) begin
                    rem <= trial[W-1:0];
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= {rem[W-2:0], quo[W-1]};
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - KW'(1);
            end else begin
                running <= 1'b0;
            end
        end
    end

    assign busy     = running;
    assign done     = running && (cnt == '0);
    assign quotient = neg ? (~quo + 1'b1) : quo;

endmodule

// File: rtl/stack_alu.sv
module stack_alu
    import stk_pkg::*;
#(
    parameter  int WIDTH = 16,
    parameter  int DEPTH = 8,
    parameter  int AW    = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    output logic             ins_ready,
    input  logic [2:0]       ins_op,
    input  logic [AW-1:0]    ins_addr,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic [WIDTH-1:0] mem_wdata,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic [CW-1:0]    depth,
    output logic             ovf_flag,
    output logic             udf_flag,
    output logic             dz_flag
);

    stk_state_e       state;
    stk_op_e          op;
    stk_act_e         act;
    logic [WIDTH-1:0] wval;
    logic [WIDTH-1:0] top;
    logic [WIDTH-1:0] second;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] div_q;
    logic [CW-1:0]    count;
    logic             fire;
    logic             full;
    logic             short;
    logic             overflow_hit;
    logic             div_zero;
    logic             div_start;
    logic             div_busy;
    logic             div_done;

    assign op    = stk_op_e'(ins_op);
    assign fire  = ins_valid && ins_ready;
    assign full  = (count == CW'(DEPTH));
    assign short = (is_binary(op) && count < CW'(2)) || (op == OP_STORE && count == '0);

    assign overflow_hit = (op == OP_LOAD) && full;
    assign div_zero     = (op == OP_DIV) && (top == '0);
    assign div_start    = fire && (op == OP_DIV) && !short && !div_zero;

    assign ins_ready = (state == ST_IDLE);
    assign mem_addr  = ins_addr;
    assign mem_wdata = top;
    assign mem_rd_en = fire && (op == OP_LOAD) && !full;
    assign mem_wr_en = fire && (op == OP_STORE) && !short;
    assign depth     = count;

    stk_store #(.W(WIDTH), .DEPTH(DEPTH)) i_store (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .wval   (wval),
        .top    (top),
        .second (second),
        .count  (count)
    );

    stk_arith #(.W(WIDTH)) i_arith (
        .op  (op),
        .lhs (second),
        .rhs (top),
        .res (arith_res)
    );

    stk_divider #(.W(WIDTH)) i_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (second),
        .divisor  (top),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_q)
    );

    always_comb begin
        act  = SA_NONE;
        wval = '0;
        case (state)
            ST_IDLE: begin
                if (fire && !short) begin
                    case (op)
                        OP_STORE: act = SA_POP;
                        OP_ADD, OP_SUB, OP_MUL: begin
                            act  = SA_MERGE;
                            wval = arith_res;
                        end
                        OP_DIV: begin
                            if (div_zero) begin
                                act  = SA_MERGE;
                                wval = '0;
                            end
                        end
                        default: act = SA_NONE;
                    endcase
                end
            end
            ST_LOAD: begin
                act  = SA_PUSH;
                wval = mem_rdata;
            end
            ST_DIVIDE: begin
                if (div_done) begin
                    act  = SA_MERGE;
                    wval = div_q;
                end
            end
            default: act = SA_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ovf_flag <= 1'b0;
            udf_flag <= 1'b0;
            dz_flag  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (mem_rd_en)      state <= ST_LOAD;
                    else if (div_start) state <= ST_DIVIDE;
                end
                ST_LOAD:   state <= ST_IDLE;
                ST_DIVIDE: if (div_done || !div_busy) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
            if (fire && overflow_hit)                 ovf_flag <= 1'b1;
            if (fire && short)                        udf_flag <= 1'b1;
            if (fire && !short && div_zero)           dz_flag  <= 1'b1;
        end
    end

endmodule

// File: rtl/stack_alu_chk.sv
module stack_alu_chk #(
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          ins_valid,
    input logic          ins_ready,
    input logic [2:0]    ins_op,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [CW-1:0] depth,
    input logic          ovf_flag,
    input logic          udf_flag,
    input logic          dz_flag
);

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        depth <= CW'(DEPTH));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    a_r9_udf_sticky: assert property (@(posedge clk) disable iff (rst)
        udf_flag |=> udf_flag);

    a_r7_dz_sticky: assert property (@(posedge clk) disable iff (rst)
        dz_flag |=> dz_flag);

    a_r3_load_stalls: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !ins_ready);

    a_r4_store_step: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> depth == $past(depth) - CW'(1));

    a_r5_merge_step: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && ins_ready && (ins_op == 3'd2 || ins_op == 3'd3 || ins_op == 3'd4)
         && depth >= CW'(2)) |=> depth == $past(depth) - CW'(1));

    a_r11_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
        !ins_ready |-> !(mem_rd_en || mem_wr_en));

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

endmodule

bind stack_alu stack_alu_chk #(.DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_stack_alu.sv
module test_stack_alu;

    localparam int W     = 16;
    localparam int DEPTH = 8;
    localparam int AW    = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ins_valid = 1'b0;
    logic          ins_ready;
    logic [2:0]    ins_op = 3'd0;
    logic [AW-1:0] ins_addr = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_en;
    logic          mem_wr_en;
    logic [W-1:0]  mem_wdata;
    logic [W-1:0]  mem_rdata;
    logic [CW-1:0] depth;
    logic          ovf_flag;
    logic          udf_flag;
    logic          dz_flag;

    logic [W-1:0]  ram [256];
    logic [W-1:0]  mdl [$];
    bit            m_ovf = 0;
    bit            m_udf = 0;
    bit            m_dz  = 0;
    int            n_chk = 0;
    int            n_err = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (mem_wr_en) ram[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= ram[mem_addr];
    end

    stack_alu #(.WIDTH(W), .DEPTH(DEPTH), .AW(AW)) i_stack_alu (
        .clk       (clk),
        .rst       (rst),
        .ins_valid (ins_valid),
        .ins_ready (ins_ready),
        .ins_op    (ins_op),
        .ins_addr  (ins_addr),
        .mem_addr  (mem_addr),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .depth     (depth),
        .ovf_flag  (ovf_flag),
        .udf_flag  (udf_flag),
        .dz_flag   (dz_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Issue one instruction, update the reference model, compare the ports.
    task automatic run(input logic [2:0] op, input logic [AW-1:0] addr, input bit stray);
        int           busy = 0;
        int           exp_busy = 0;
        string        tag = "R2 no-op";
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] r;
        @(negedge clk);
        chk(ins_ready == 1'b1, "R11 ready before issue", int'(ins_ready), 1);
        ins_valid = 1'b1;
        ins_op    = op;
        ins_addr  = addr;
        #1;
        case (op)
            3'd0: begin
                tag = "R3 load";
                if (mdl.size() == DEPTH) begin
                    m_ovf = 1;
                    tag = "R8 overflow";
                    chk(!mem_rd_en, "R8 no read when full", int'(mem_rd_en), 0);
                end else begin
                    chk(mem_rd_en && mem_addr == addr, "R3 read strobe", int'(mem_addr), int'(addr));
                    mdl.push_back(ram[addr]);
                    exp_busy = 1;
                end
            end
            3'd1: begin
                tag = "R4 store";
                if (mdl.size() == 0) begin
                    m_udf = 1;
                    tag = "R9 store empty";
                    chk(!mem_wr_en, "R9 no write when empty", int'(mem_wr_en), 0);
                end else begin
                    r = mdl.pop_back();
                    chk(mem_wr_en && mem_addr == addr && mem_wdata == r,
                        "R4 write data", int'(mem_wdata), int'(r));
                end
            end
            3'd2, 3'd3, 3'd4, 3'd5: begin
                tag = (op == 3'd5) ? "R6 divide" : "R5 arith";
                if (mdl.size() < 2) begin
                    m_udf = 1;
                    tag = "R9 underflow";
                end else begin
                    b = mdl.pop_back();
                    a = mdl.pop_back();
                    case (op)
                        3'd2: r = a + b;
                        3'd3: r = a - b;
                        3'd4: r = a * b;
                        default: begin
                            if (b == '0) begin
                                r = '0;
                                m_dz = 1;
                                tag = "R7 divide by zero";
                            end else begin
                                r = W'(int'($signed(a)) / int'($signed(b)));
                                exp_busy = W + 1;
                            end
                        end
                    endcase
                    mdl.push_back(r);
                end
            end
            default: ;
        endcase
        @(negedge clk);
        ins_valid = stray;
        ins_op    = 3'd1;
        ins_addr  = 8'd200;
        while (!ins_ready && busy < 64) begin
            busy++;
            #1;
            chk(!mem_wr_en && !mem_rd_en, "R11 stray ignored", int'(mem_wr_en), 0);
            @(negedge clk);
        end
        ins_valid = 1'b0;
        chk(busy == exp_busy, {tag, " stall cycles"}, busy, exp_busy);
        chk(int'(depth) == mdl.size(), {tag, " depth"}, int'(depth), mdl.size());
        chk(ovf_flag == m_ovf && udf_flag == m_udf && dz_flag == m_dz, {tag, " flags"},
            int'({ovf_flag, udf_flag, dz_flag}), int'({m_ovf, m_udf, m_dz}));
    endtask

    task automatic load_and_div(input logic [W-1:0] x, input logic [W-1:0] y,
                                input logic [W-1:0] exp_q, input string tag);
        ram[20] = x;
        ram[21] = y;
        run(3'd0, 8'd20, 0);
        run(3'd0, 8'd21, 0);
        run(3'd5, 8'd0, 1);
        run(3'd1, 8'd30, 0);
        chk(ram[30] == exp_q, tag, int'(ram[30]), int'(exp_q));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = '0;
        ram[1] = 16'd100;
        ram[2] = 16'd40;
        ram[3] = 16'd10;
        ram[4] = 16'd3;
        ram[5] = 16'hFFFE;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(depth == '0, "R1 depth after reset", int'(depth), 0);
        chk(!ovf_flag && !udf_flag && !dz_flag, "R1 flags after reset",
            int'({ovf_flag, udf_flag, dz_flag}), 0);
        chk(ins_ready == 1'b1, "R1 ready after reset", int'(ins_ready), 1);

        // R10 postfix expression, stray stalls during loads and divide (R11)
        run(3'd0, 8'd1, 1);
        run(3'd0, 8'd2, 0);
        run(3'd3, 8'd0, 0);
        run(3'd0, 8'd3, 0);
        run(3'd0, 8'd4, 0);
        run(3'd0, 8'd5, 1);
        run(3'd4, 8'd0, 0);
        run(3'd2, 8'd0, 0);
        run(3'd5, 8'd0, 1);
        run(3'd1, 8'd10, 0);
        chk(ram[10] == 16'd15, "R10 expression result", int'(ram[10]), 15);
        chk(ram[200] == '0, "R11 stray store never taken", int'(ram[200]), 0);

        // R6 signed truncating division cases
        load_and_div(16'hFFF9, 16'd2, 16'hFFFD, "R6 -7/2");
        load_and_div(16'd7, 16'hFFFE, 16'hFFFD, "R6 7/-2");
        load_and_div(16'h8000, 16'hFFFF, 16'h8000, "R6 min/-1");
        load_and_div(16'd1000, 16'd7, 16'd142, "R6 1000/7");

        // R5 operand order and wrap
        ram[22] = 16'd3;
        ram[23] = 16'd300;
        run(3'd0, 8'd22, 0);
        run(3'd0, 8'd4, 0);
        run(3'd3, 8'd0, 0);
        run(3'd1, 8'd31, 0);
        chk(ram[31] == 16'd0, "R5 3-3", int'(ram[31]), 0);
        run(3'd0, 8'd23, 0);
        run(3'd0, 8'd23, 0);
        run(3'd4, 8'd0, 0);
        run(3'd1, 8'd32, 0);
        chk(ram[32] == 16'd24464, "R5 300*300 wrap", int'(ram[32]), 24464);
        run(3'd0, 8'd22, 0);
        run(3'd0, 8'd3, 0);
        run(3'd3, 8'd0, 0);
        run(3'd1, 8'd33, 0);
        chk(ram[33] == 16'hFFF9, "R5 3-10 order", int'(ram[33]), 65529);

        // R2 reserved codes
        run(3'd0, 8'd2, 0);
        run(3'd6, 8'd0, 0);
        run(3'd7, 8'd0, 0);
        run(3'd1, 8'd34, 0);
        chk(ram[34] == 16'd40, "R2 reserved codes keep top", int'(ram[34]), 40);

        // R9 underflow with zero top on divide: underflow wins over divide by zero
        run(3'd0, 8'd0, 0);
        run(3'd5, 8'd0, 0);
        chk(!dz_flag, "R9 underflow precedence over dz", int'(dz_flag), 0);
        run(3'd1, 8'd35, 0);
        run(3'd1, 8'd36, 0);
        run(3'd2, 8'd0, 0);

        // R7 divide by zero
        ram[24] = 16'd5;
        run(3'd0, 8'd24, 0);
        run(3'd0, 8'd0, 0);
        run(3'd5, 8'd0, 0);
        run(3'd1, 8'd37, 0);
        chk(ram[37] == '0, "R7 zero result", int'(ram[37]), 0);
        run(3'd0, 8'd24, 0);
        run(3'd1, 8'd38, 0);
        chk(dz_flag, "R7 flag sticky", int'(dz_flag), 1);

        // R8 overflow then LIFO drain
        for (int i = 0; i < DEPTH; i++) begin
            ram[40 + i] = W'(1000 + i);
            run(3'd0, AW'(40 + i), 0);
        end
        ram[60] = 16'd777;
        run(3'd0, 8'd60, 0);
        for (int i = 0; i < DEPTH; i++) begin
            run(3'd1, AW'(70 + i), 0);
            chk(ram[70 + i] == W'(1000 + DEPTH - 1 - i), "R8 LIFO after overflow",
                int'(ram[70 + i]), 1000 + DEPTH - 1 - i);
        end

        summary();
        $finish;
    end

endmodule